// File: doc/BRIEF.md
# Clock Multiplier Boost Controller

This block keeps a 16-bit clock-control word, written through a single-cycle write strobe, and turns it into the clock figures a decoder core runs on. The word carries a crystal-frequency code, a base multiplier code and a code for how much temporary headroom above the base is allowed. From these the block reports the crystal frequency in kHz, the multiplier now in force (in half-units, where 2 means ×1.0), the core clock that results and the highest sample rate the crystal can support.

While a boost-capable decode mode is active, boost-up and boost-down request pins can move the multiplier in force by one half-step at a time. The multiplier cannot go above the base plus the allowed headroom, and it cannot go below the base. A programmable gap limits how often steps are taken. When the mode drops, the multiplier returns to the base. When the word is rewritten during the mode, the multiplier is pulled back into the new range. The clock generator itself and the firmware that decides on demand are outside this block. Demand is represented by the request pins.

Top module: `clkmul_boost_ctrl`

## Requirements
- R1: After reset the control word is 0, `act_half` is 2, `xtal_khz` is 12288, `core_khz` is 12288 and `max_rate_hz` is 48000.
- R2: A write stores `cfg_wdata` on that clock edge. The frequency code sits in bits 10:0. From that edge `xtal_khz` equals code×4+8000, and a code of 0 means 12288.
- R3: The base multiplier code sits in bits 15:13. The base in half-units is code+2, so codes 0 to 7 give ×1.0 to ×4.5. With the mode inactive, `act_half` equals the base one edge after the word changes.
- R4: `core_khz` always equals `xtal_khz`×`act_half`/2.
- R5: `max_rate_hz` always equals floor(`xtal_khz`×1000/256).
- R6: The headroom code sits in bits 12:11. The ceiling is base+code half-units, and code 0 allows no raise. With the mode active and a step allowed, a lone `boost_up` raises `act_half` by exactly 1 on the next edge, up to the ceiling.
- R7: With the mode active, a lone `boost_down` lowers `act_half` by exactly 1, but never below the base. An up request at the ceiling, a down request at the base, and both requests together are all ignored: `act_half` keeps its value.
- R8: After a step is taken, the next step is taken no sooner than `step_gap`+1 edges later. Requests in between are ignored. With a gap of 0 a step can be taken on every edge.
- R9: When `boost_mode` is low on an edge, `act_half` becomes the base on that edge, whatever boost was in force.
- R10: If the word is rewritten while the mode is active and `act_half` falls outside the new base-to-ceiling range, `act_half` is clamped to the nearest end of that range on the next edge.
- R11: With `boost_mode` low, boost requests have no effect on `act_half`.
- R12: Writing 0x9BE8 gives `xtal_khz` 12000, a base of 6 half-units and a core clock of 36000 kHz. Full boost then reaches 9 half-units and 54000 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word value to store |
| boost_mode | input | 1 | Boost-capable decode mode is active |
| boost_up | input | 1 | Request one half-step more |
| boost_down | input | 1 | Request one half-step less |
| step_gap | input | 8 | Minimum idle edges between taken steps |
| act_half | output | 4 | Multiplier in force, in half-units |
| xtal_khz | output | 14 | Crystal frequency in kHz |
| core_khz | output | 17 | Resulting core clock in kHz |
| max_rate_hz | output | 16 | Highest supported sample rate in Hz |

## Verification
A write is visible on `xtal_khz` and `max_rate_hz` right after the edge that takes it. `act_half` reacts one edge after the inputs or the stored word that drive it, and `core_khz` tracks `act_half` with no further delay. The bench applies each input set at a falling edge. After the rising edge it advances its own model by exactly one step, using the word held before that edge, and samples all four outputs a short delay later. Because of this ordering, the one-edge lag of a clamp after a rewrite and the spacing set by `step_gap` are checked in the cycle where they are due.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;

    localparam int CFG_W      = 16;
    localparam int MULT_MSB   = 15;
    localparam int MULT_LSB   = 13;
    localparam int ADD_MSB    = 12;
    localparam int ADD_LSB    = 11;
    localparam int FREQ_MSB   = 10;
    localparam int MULT_W     = MULT_MSB - MULT_LSB + 1;
    localparam int ADD_W      = ADD_MSB - ADD_LSB + 1;
    localparam int FREQ_W     = FREQ_MSB + 1;

    localparam int HALF_W     = 4;
    localparam int XTAL_W     = 14;
    localparam int PROD_W     = XTAL_W + HALF_W;
    localparam int CORE_W     = PROD_W - 1;
    localparam int RATE_MUL   = 125;
    localparam int RATE_SHIFT = 5;
    localparam int RATE_PW    = XTAL_W + 7;
    localparam int RATE_W     = RATE_PW - RATE_SHIFT;

    localparam int XTAL_DEF_KHZ  = 12288;
    localparam int XTAL_BASE_KHZ = 8000;
    localparam int XTAL_STEP_SH  = 2;
    localparam int HALF_ONE      = 2;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [HALF_W-1:0] act;
    } ctrl_state_t;

endpackage

// File: rtl/clkmul_decode.sv
module clkmul_decode
    import clkmul_pkg::*;
(
    input  logic [CFG_W-1:0]  cfg,
    output logic [HALF_W-1:0] base_half,
    output logic [HALF_W-1:0] ceil_half,
    output logic [XTAL_W-1:0] xtal_khz
);
    logic [MULT_W-1:0] mult_code;
    logic [ADD_W-1:0]  add_code;
    logic [FREQ_W-1:0] freq_code;

    always_comb begin
        mult_code = cfg[MULT_MSB:MULT_LSB];
        add_code  = cfg[ADD_MSB:ADD_LSB];
        freq_code = cfg[FREQ_MSB:0];
        base_half = HALF_W'(mult_code) + HALF_W'(HALF_ONE);
        ceil_half = base_half + HALF_W'(add_code);
        if (freq_code == '0) begin
            xtal_khz = XTAL_W'(XTAL_DEF_KHZ);
        end else begin
            xtal_khz = (XTAL_W'(freq_code) << XTAL_STEP_SH) + XTAL_W'(XTAL_BASE_KHZ);
        end
    end
endmodule

// File: rtl/clkmul_pace.sv
module clkmul_pace #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [GAP_W-1:0] gap,
    output logic             ready
);
    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (take) begin
            cnt_d = gap;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - GAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/clkmul_scale.sv
module clkmul_scale
    import clkmul_pkg::*;
(
    input  logic [XTAL_W-1:0] xtal_khz,
    input  logic [HALF_W-1:0] act_half,
    output logic [CORE_W-1:0] core_khz,
    output logic [RATE_W-1:0] max_rate_hz
);
    logic [PROD_W-1:0]  core_prod;
    logic [RATE_PW-1:0] rate_prod;

    always_comb begin
        core_prod   = PROD_W'(xtal_khz) * PROD_W'(act_half);
        core_khz    = core_prod[PROD_W-1:1];
        rate_prod   = RATE_PW'(xtal_khz) * RATE_PW'(RATE_MUL);
        max_rate_hz = rate_prod[RATE_PW-1:RATE_SHIFT];
    end
endmodule

// File: rtl/clkmul_boost_ctrl.sv
module clkmul_boost_ctrl
    import clkmul_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              boost_mode,
    input  logic              boost_up,
    input  logic              boost_down,
    input  logic [GAP_W-1:0]  step_gap,
    output logic [HALF_W-1:0] act_half,
    output logic [XTAL_W-1:0] xtal_khz,
    output logic [CORE_W-1:0] core_khz,
    output logic [RATE_W-1:0] max_rate_hz
);
    ctrl_state_t       st_d, st_q;
    logic [HALF_W-1:0] base_half, ceil_half;
    logic              step_ready, step_take;
    logic [CFG_W-1:0]  cfg_q;

    assign cfg_q = st_q.cfg;

    clkmul_decode u_decode (
        .cfg       (st_q.cfg),
        .base_half (base_half),
        .ceil_half (ceil_half),
        .xtal_khz  (xtal_khz)
    );

    clkmul_pace #(.GAP_W(GAP_W)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (step_take),
        .gap   (step_gap),
        .ready (step_ready)
    );

    clkmul_scale u_scale (
        .xtal_khz    (xtal_khz),
        .act_half    (st_q.act),
        .core_khz    (core_khz),
        .max_rate_hz (max_rate_hz)
    );

    always_comb begin
        st_d      = st_q;
        step_take = 1'b0;
        if (cfg_wr) begin
            st_d.cfg = cfg_wdata;
        end
        if (!boost_mode) begin
            st_d.act = base_half;
        end else if (st_q.act < base_half) begin
            st_d.act = base_half;
        end else if (st_q.act > ceil_half) begin
            st_d.act = ceil_half;
        end else if (step_ready && (boost_up ^ boost_down)) begin
            if (boost_up && (st_q.act < ceil_half)) begin
                st_d.act  = st_q.act + HALF_W'(1);
                step_take = 1'b1;
            end else if (boost_down && (st_q.act > base_half)) begin
                st_d.act  = st_q.act - HALF_W'(1);
                step_take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= '0;
            st_q.act <= HALF_W'(HALF_ONE);
        end else begin
            st_q <= st_d;
        end
    end

    assign act_half = st_q.act;
endmodule

// File: rtl/clkmul_boost_ctrl_chk.sv
module clkmul_boost_ctrl_chk
    import clkmul_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              boost_mode,
    input logic              step_ready,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [HALF_W-1:0] act_half,
    input logic [XTAL_W-1:0] xtal_khz
);
    logic [HALF_W-1:0] chk_base, chk_ceil;
    logic              in_range;

    assign chk_base = {1'b0, cfg_q[MULT_MSB:MULT_LSB]} + 4'd2;
    assign chk_ceil = chk_base + {2'b00, cfg_q[ADD_MSB:ADD_LSB]};
    assign in_range = (act_half >= chk_base) && (act_half <= chk_ceil);

    assert_default_xtal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[FREQ_MSB:0] == '0) |-> (xtal_khz == XTAL_W'(XTAL_DEF_KHZ)));

    assert_half_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_mode && in_range) |=>
            (act_half == $past(act_half) || act_half == $past(act_half) + 4'd1 ||
             act_half + 4'd1 == $past(act_half)));

    assert_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_mode && in_range) |=>
            (act_half <= $past(chk_ceil) && act_half >= $past(chk_base)));

    assert_paced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_mode && in_range && !step_ready) |=> (act_half == $past(act_half)));

    assert_mode_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!boost_mode) |=> (act_half == $past(chk_base)));

    assert_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_mode && (act_half > chk_ceil)) |=> (act_half == $past(chk_ceil)));
endmodule

bind clkmul_boost_ctrl clkmul_boost_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boost_mode (boost_mode),
    .step_ready (step_ready),
    .cfg_q      (cfg_q),
    .act_half   (act_half),
    .xtal_khz   (xtal_khz)
);

// File: tb/clkmul_boost_ctrl_tb.sv
module clkmul_boost_ctrl_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        boost_mode = 1'b0, boost_up = 1'b0, boost_down = 1'b0;
    logic [7:0]  step_gap = '0;
    logic [3:0]  act_half;
    logic [13:0] xtal_khz;
    logic [16:0] core_khz;
    logic [15:0] max_rate_hz;

    int total = 0, bad = 0;
    int m_cfg = 0, m_act = 2, m_cnt = 0;

    always #(PERIOD/2) clk = ~clk;

    clkmul_boost_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .boost_mode(boost_mode), .boost_up(boost_up), .boost_down(boost_down),
        .step_gap(step_gap), .act_half(act_half), .xtal_khz(xtal_khz),
        .core_khz(core_khz), .max_rate_hz(max_rate_hz)
    );

    function automatic int f_xtal(int c);
        int code = c & 16'h07FF;
        return (code == 0) ? 12288 : code * 4 + 8000;
    endfunction
    function automatic int f_base(int c);
        return ((c >> 13) & 7) + 2;
    endfunction
    function automatic int f_ceil(int c);
        return f_base(c) + ((c >> 11) & 3);
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic cyc(logic wr, logic [15:0] d, logic md, logic up, logic dn, string tag);
        bit took;
        @(negedge clk);
        cfg_wr = wr; cfg_wdata = d; boost_mode = md; boost_up = up; boost_down = dn;
        @(posedge clk);
        took = 0;
        if (!md) m_act = f_base(m_cfg);
        else if (m_act < f_base(m_cfg)) m_act = f_base(m_cfg);
        else if (m_act > f_ceil(m_cfg)) m_act = f_ceil(m_cfg);
        else if (m_cnt == 0 && (up ^ dn)) begin
            if (up && m_act < f_ceil(m_cfg)) begin m_act++; took = 1; end
            else if (dn && m_act > f_base(m_cfg)) begin m_act--; took = 1; end
        end
        if (took) m_cnt = int'(step_gap);
        else if (m_cnt != 0) m_cnt--;
        if (wr) m_cfg = int'(d);
        #1;
        chk(tag, "act_half", int'(act_half), m_act);
        chk("R2", "xtal_khz", int'(xtal_khz), f_xtal(m_cfg));
        chk("R4", "core_khz", int'(core_khz), f_xtal(m_cfg) * m_act / 2);
        chk("R5", "max_rate_hz", int'(max_rate_hz), f_xtal(m_cfg) * 1000 / 256);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "act_half", int'(act_half), 2);
        chk("R1", "xtal_khz", int'(xtal_khz), 12288);
        chk("R1", "core_khz", int'(core_khz), 12288);
        chk("R1", "max_rate_hz", int'(max_rate_hz), 48000);
        @(negedge clk); rst_n = 1'b1;

        cyc(1, 16'h9BE8, 0, 0, 0, "R12");
        cyc(0, 0, 0, 0, 0, "R3");
        chk("R3", "base act_half", int'(act_half), 6);
        chk("R12", "xtal_khz", int'(xtal_khz), 12000);
        chk("R12", "core_khz", int'(core_khz), 36000);

        cyc(0, 0, 0, 1, 0, "R11");
        chk("R11", "act_half idle up", int'(act_half), 6);
        repeat (3) cyc(0, 0, 1, 1, 0, "R6");
        chk("R6", "act_half boosted", int'(act_half), 9);
        chk("R12", "core_khz ceiling", int'(core_khz), 54000);
        cyc(0, 0, 1, 1, 0, "R7");
        chk("R7", "act_half above ceiling", int'(act_half), 9);
        cyc(0, 0, 1, 1, 1, "R7");
        chk("R7", "act_half both req", int'(act_half), 9);
        repeat (5) cyc(0, 0, 1, 0, 1, "R7");
        chk("R7", "act_half floor", int'(act_half), 6);

        cyc(0, 0, 1, 1, 0, "R6");
        cyc(0, 0, 1, 1, 0, "R6");
        cyc(0, 0, 0, 0, 0, "R9");
        chk("R9", "act_half mode end", int'(act_half), 6);

        step_gap = 8'd3;
        cyc(0, 0, 1, 0, 0, "R8");
        repeat (4) cyc(0, 0, 1, 1, 0, "R8");
        chk("R8", "act_half paced", int'(act_half), 7);
        cyc(0, 0, 1, 1, 0, "R8");
        chk("R8", "act_half next step", int'(act_half), 8);
        repeat (4) cyc(0, 0, 1, 1, 0, "R8");
        chk("R8", "act_half reach ceil", int'(act_half), 9);

        step_gap = 8'd0;
        cyc(1, 16'h4000, 1, 0, 0, "R10");
        cyc(0, 0, 1, 0, 0, "R10");
        chk("R10", "act_half clamped", int'(act_half), 4);

        for (int i = 0; i < 4000; i++) begin
            logic wr, md, up, dn;
            logic [15:0] d;
            wr = ($urandom % 25) == 0;
            d  = 16'($urandom);
            md = ($urandom % 8) != 0;
            up = ($urandom % 3) == 0;
            dn = ($urandom % 4) == 0;
            if (($urandom % 200) == 0) step_gap = 8'($urandom % 4);
            cyc(wr, d, md, up, dn, "R6");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule